// File: doc/BRIEF.md
# Serial Multichannel Pin Mode Controller

This block is the digital control core of a multichannel pin-electronics front end. A slow three-wire serial port (serial clock, serial data, active-low select) fills a shift register. When the select line rises, the word is taken into an input register. The word holds six mode bits and one update-enable bit per channel. A level-sensitive load line then passes the mode bits into a latch for each channel. The latch follows the input register while the load line is low and freezes once it goes high. Only channels whose update-enable bit is set take the new bits.

Each channel's latched bits are combined with that channel's fast drive-data and receive inputs. The result is a driver-state code plus four switch enables (sense, force, low load resistor, high load resistor). The comparator flags of each channel pass straight through. The serial port has its own output, which repeats the bits pushed out of the shift register so that several devices can share one chain.

The serial clock, select and load lines are asynchronous to the system clock and are brought in through two-flop synchronizers. A state machine with three states handles a frame: SP_IDLE (select high), SP_SHIFT (select low, bits are shifted) and SP_CAPTURE (one cycle, the word goes to the input register). The transitions are these:
- SP_IDLE goes to SP_SHIFT when the synchronized select is low; the bit counter clears.
- SP_SHIFT goes to SP_CAPTURE when select is high again.
- SP_CAPTURE goes to SP_IDLE unconditionally.

A frame whose length is not exactly the word length sets a sticky error flag. The word is still captured.

Top module: `pin_mode_ctrl`

## Requirements
- R1: After reset every channel latch holds all mode bits 0, the input register holds mode 0 with all four channel-update bits at 1, frame_err is 0 and dout is 0. With rcv_in=0 and data_in=0, each channel's drv_state is 0 (drive low) and every enable is 0.
- R2: Serial bits are taken on each rising serial clock edge while cs_n is low, least significant bit first. The rising edge of cs_n moves the 12-bit word into the input register. Mode bit positions are 0 term, 1 low-leak, 2 sense enable, 3 force enable, 4 low load enable and 5 high load enable. Word bits 6 and 7 have no effect on any output.
- R3: Word bits 8, 9, 10 and 11 allow updates of channels 0, 1, 2 and 3. A channel whose bit is 0 keeps its latched mode bits.
- R4: While ld is high the channel latches do not change, even when new words arrive. When ld goes low, the selected channels take the input register's mode bits.
- R5: With ld held low, a captured word reaches the selected channel latches without any ld activity.
- R6: drv_state per channel (3 bits at [3i+2:3i]) is 4 (low-leak) whenever the latched low-leak bit is set. Otherwise, with rcv_in=0 it is 1 if data_in=1 and 0 if data_in=0. With rcv_in=1 it is 3 (terminate) if the term bit is set and 2 (high impedance) if not.
- R7: cmp_hi_out and cmp_lo_out equal cmp_hi_in and cmp_lo_in bit for bit, channel by channel.
- R8: A frame with other than 12 rising serial clock edges still captures the shift register contents and sets frame_err. frame_err stays set until err_clr is pulsed high, and err_clr clears it.
- R9: dout changes only after a falling serial clock edge inside a frame. After the k-th falling edge it shows the bit that the k-th rising edge pushed out of the register's far end, which is the bit received 12 rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, asynchronous |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| din | input | 1 | Serial data in |
| ld | input | 1 | Latch load line, transparent while low |
| err_clr | input | 1 | Synchronous pulse that clears frame_err |
| dout | output | 1 | Serial data out for chaining |
| frame_err | output | 1 | Sticky wrong-length frame flag |
| data_in | input | 4 | Per-channel drive data |
| rcv_in | input | 4 | Per-channel receive select |
| cmp_hi_in | input | 4 | Per-channel high comparator flag |
| cmp_lo_in | input | 4 | Per-channel low comparator flag |
| drv_state | output | 12 | Per-channel driver state code, 3 bits each |
| sense_en | output | 4 | Per-channel sense switch enable |
| force_en | output | 4 | Per-channel force switch enable |
| load_lo_en | output | 4 | Per-channel low load resistor enable |
| load_hi_en | output | 4 | Per-channel high load resistor enable |
| cmp_hi_out | output | 4 | High comparator flags, passed through |
| cmp_lo_out | output | 4 | Low comparator flags, passed through |

## Verification
The assertions assume that sclk stays in each level for at least two system clocks, so that no edge is lost in the synchronizers. They also assume that din is stable from before a synchronized rising edge until after it, and that cs_n never moves in the same system cycle as a serial clock edge. The bench drives every serial level for four or more system clocks and changes din only well after a falling edge. It waits several cycles between select, clock and load transitions, so every input stays inside these limits.

// File: rtl/pin_mode_ctrl_pkg.sv
package pin_mode_ctrl_pkg;
    localparam int MODE_W = 6;
    localparam int PAD_W  = 2;
    localparam int ST_W   = 3;

    localparam int B_TERM  = 0;
    localparam int B_LLEAK = 1;
    localparam int B_SENSE = 2;
    localparam int B_FORCE = 3;
    localparam int B_LDLO  = 4;
    localparam int B_LDHI  = 5;

    typedef enum logic [ST_W-1:0] {
        DRV_LOW   = 3'd0,
        DRV_HIGH  = 3'd1,
        DRV_HIZ   = 3'd2,
        DRV_TERM  = 3'd3,
        DRV_LLEAK = 3'd4
    } drv_state_e;

    typedef enum logic [1:0] {
        SP_IDLE    = 2'd0,
        SP_SHIFT   = 2'd1,
        SP_CAPTURE = 2'd2
    } sp_state_e;
endpackage

// File: rtl/pin_mode_sync.sv
module pin_mode_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic lvl
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
        end
    end

    assign lvl = chain_q[STAGES-1];
endmodule

// File: rtl/pin_mode_serial_fsm.sv
module pin_mode_serial_fsm
    import pin_mode_ctrl_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int WORD_W = MODE_W + PAD_W + NCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              sclk_lvl,
    input  logic              din,
    input  logic              err_clr,
    output logic              dout,
    output logic              frame_err,
    output logic [MODE_W-1:0] mode_reg,
    output logic [NCH-1:0]    mask_reg
);
    localparam int CNT_W = $clog2(WORD_W + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(WORD_W);

    sp_state_e          state_q, state_d;
    logic [WORD_W-1:0]  sr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sclk_prev_q;
    logic               spill_q;
    logic               sclk_rise, sclk_fall;

    assign sclk_rise = sclk_lvl & ~sclk_prev_q;
    assign sclk_fall = ~sclk_lvl & sclk_prev_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SP_IDLE:    if (!cs_lvl) state_d = SP_SHIFT;
            SP_SHIFT:   if (cs_lvl)  state_d = SP_CAPTURE;
            SP_CAPTURE: state_d = SP_IDLE;
            default:    state_d = SP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SP_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q        <= '0;
            cnt_q       <= '0;
            sclk_prev_q <= 1'b0;
            spill_q     <= 1'b0;
            dout        <= 1'b0;
            frame_err   <= 1'b0;
            mode_reg    <= '0;
            mask_reg    <= {NCH{1'b1}};
        end else begin
            sclk_prev_q <= sclk_lvl;
            if (state_q == SP_IDLE && !cs_lvl) begin
                cnt_q <= '0;
            end
            if (state_q == SP_SHIFT && sclk_rise) begin
                sr_q    <= {din, sr_q[WORD_W-1:1]};
                spill_q <= sr_q[0];
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == SP_SHIFT && sclk_fall) begin
                dout <= spill_q;
            end
            if (state_q == SP_CAPTURE) begin
                mode_reg <= sr_q[MODE_W-1:0];
                mask_reg <= sr_q[WORD_W-1 -: NCH];
            end
            frame_err <= (frame_err & ~err_clr) |
                         ((state_q == SP_CAPTURE) && (cnt_q != CNT_OK));
        end
    end

    AST_INREG_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SP_CAPTURE) |=> ($stable(mode_reg) && $stable(mask_reg))); // R2
    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !err_clr) |=> frame_err); // R8
    AST_FERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && state_q != SP_CAPTURE) |=> !frame_err); // R8
    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == SP_SHIFT && sclk_fall) |=> $stable(dout)); // R9
endmodule

// File: rtl/pin_mode_chan_latch.sv
module pin_mode_chan_latch
    import pin_mode_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lvl,
    input  logic              sel,
    input  logic [MODE_W-1:0] mode_in,
    output logic [MODE_W-1:0] mode_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              mode_q <= '0;
        else if (!ld_lvl && sel) mode_q <= mode_in;
    end

    AST_LD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lvl |=> $stable(mode_q)); // R4
    AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(mode_q)); // R3
endmodule

// File: rtl/pin_mode_chan_decode.sv
module pin_mode_chan_decode
    import pin_mode_ctrl_pkg::*;
(
    input  logic            term,
    input  logic            lleak,
    input  logic            data,
    input  logic            rcv,
    output logic [ST_W-1:0] state
);
    drv_state_e st;

    always_comb begin
        if (lleak)     st = DRV_LLEAK;
        else if (!rcv) st = data ? DRV_HIGH : DRV_LOW;
        else           st = term ? DRV_TERM : DRV_HIZ;
    end

    assign state = st;
endmodule

// File: rtl/pin_mode_ctrl.sv
module pin_mode_ctrl
    import pin_mode_ctrl_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                din,
    input  logic                ld,
    input  logic                err_clr,
    output logic                dout,
    output logic                frame_err,
    input  logic [NCH-1:0]      data_in,
    input  logic [NCH-1:0]      rcv_in,
    input  logic [NCH-1:0]      cmp_hi_in,
    input  logic [NCH-1:0]      cmp_lo_in,
    output logic [NCH*ST_W-1:0] drv_state,
    output logic [NCH-1:0]      sense_en,
    output logic [NCH-1:0]      force_en,
    output logic [NCH-1:0]      load_lo_en,
    output logic [NCH-1:0]      load_hi_en,
    output logic [NCH-1:0]      cmp_hi_out,
    output logic [NCH-1:0]      cmp_lo_out
);
    localparam int WORD_W = MODE_W + PAD_W + NCH;

    logic              sclk_lvl, cs_lvl, ld_lvl;
    logic [MODE_W-1:0] mode_reg;
    logic [NCH-1:0]    mask_reg;

    pin_mode_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .async_in(sclk), .lvl(sclk_lvl));
    pin_mode_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .async_in(cs_n), .lvl(cs_lvl));
    pin_mode_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sync_ld (
        .clk(clk), .rst_n(rst_n), .async_in(ld), .lvl(ld_lvl));

    pin_mode_serial_fsm #(.NCH(NCH), .WORD_W(WORD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .sclk_lvl(sclk_lvl),
        .din(din), .err_clr(err_clr), .dout(dout), .frame_err(frame_err),
        .mode_reg(mode_reg), .mask_reg(mask_reg));

    assign cmp_hi_out = cmp_hi_in;
    assign cmp_lo_out = cmp_lo_in;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic [MODE_W-1:0] lat;
        logic [ST_W-1:0]   st;

        pin_mode_chan_latch u_latch (
            .clk(clk), .rst_n(rst_n), .ld_lvl(ld_lvl), .sel(mask_reg[i]),
            .mode_in(mode_reg), .mode_q(lat));

        pin_mode_chan_decode u_dec (
            .term(lat[B_TERM]), .lleak(lat[B_LLEAK]),
            .data(data_in[i]), .rcv(rcv_in[i]), .state(st));

        assign drv_state[i*ST_W +: ST_W] = st;
        assign sense_en[i]   = lat[B_SENSE];
        assign force_en[i]   = lat[B_FORCE];
        assign load_lo_en[i] = lat[B_LDLO];
        assign load_hi_en[i] = lat[B_LDHI];

        AST_LLEAK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            lat[B_LLEAK] |-> (st == DRV_LLEAK)); // R6
        AST_RCV_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (rcv_in[i] && !lat[B_LLEAK]) |-> (st == DRV_HIZ || st == DRV_TERM)); // R6
    end
endmodule

// File: tb/pin_mode_ctrl_bench.sv
module pin_mode_ctrl_bench;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0, ld = 1'b0, err_clr = 1'b0;
    logic dout, frame_err;
    logic [NCH-1:0] data_in = '0, rcv_in = '0, cmp_hi_in = '0, cmp_lo_in = '0;
    logic [NCH*3-1:0] drv_state;
    logic [NCH-1:0] sense_en, force_en, load_lo_en, load_hi_en, cmp_hi_out, cmp_lo_out;

    always #4 clk = ~clk;

    pin_mode_ctrl #(.NCH(NCH)) u_pin_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din), .ld(ld),
        .err_clr(err_clr), .dout(dout), .frame_err(frame_err),
        .data_in(data_in), .rcv_in(rcv_in), .cmp_hi_in(cmp_hi_in), .cmp_lo_in(cmp_lo_in),
        .drv_state(drv_state), .sense_en(sense_en), .force_en(force_en),
        .load_lo_en(load_lo_en), .load_hi_en(load_hi_en),
        .cmp_hi_out(cmp_hi_out), .cmp_lo_out(cmp_lo_out));

    int total = 0, fails = 0;
    logic [11:0] m_sr = '0;
    logic [5:0]  m_mode = '0;
    logic [3:0]  m_mask = 4'hF;
    logic [5:0]  m_lat [NCH];
    logic        m_ferr = 1'b0;
    logic        dout_seen [16];

    task automatic chk(input string r, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %0h expected %0h", r, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [2:0] exp_state(logic [5:0] md, logic d, logic r);
        if (md[1]) return 3'd4;
        if (!r)    return d ? 3'd1 : 3'd0;
        return md[0] ? 3'd3 : 3'd2;
    endfunction

    task automatic apply_model();
        for (int i = 0; i < NCH; i++) if (m_mask[i]) m_lat[i] = m_mode;
    endtask

    task automatic send_bits(input logic [15:0] w, input int n);
        cs_n = 1'b0;
        tick(6);
        for (int k = 0; k < n; k++) begin
            din = w[k];
            tick(4);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(6);
            dout_seen[k] = dout;
            m_sr = {w[k], m_sr[11:1]};
        end
        tick(2);
        cs_n = 1'b1;
        tick(8);
        m_mode = m_sr[5:0];
        m_mask = m_sr[11:8];
        if (n != 12) m_ferr = 1'b1;
        if (!ld) apply_model();
    endtask

    task automatic check_chans(input string r);
        for (int i = 0; i < NCH; i++) begin
            chk(r, {28'd0, load_hi_en[i], load_lo_en[i], force_en[i], sense_en[i]},
                {28'd0, m_lat[i][5:2]});
            chk(r, {29'd0, drv_state[i*3 +: 3]},
                {29'd0, exp_state(m_lat[i], data_in[i], rcv_in[i])});
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [11:0] wa, wb;
        for (int i = 0; i < NCH; i++) m_lat[i] = '0;
        tick(10);
        rst_n = 1'b1;
        tick(5);
        // R1 reset state
        check_chans("R1");
        chk("R1 frame_err", {31'd0, frame_err}, 32'd0);
        chk("R1 dout", {31'd0, dout}, 32'd0);

        // R2 / R3 / R5: sweep all masks, ld held low, pad bits set
        for (int m = 0; m < 16; m++) begin
            logic [5:0] md;
            md = 6'((m * 11 + 5) & 63);
            send_bits({4'd0, 4'(m), 2'b11, md}, 12);
            data_in = 4'(m);
            rcv_in  = 4'(m >> 1);
            tick(1);
            check_chans("R3 R2 R5");
        end

        // R6: exhaustive decode over term/low-leak and data/rcv
        for (int tl = 0; tl < 4; tl++) begin
            send_bits({4'd0, 4'hF, 2'b00, 4'b1010, 2'(tl)}, 12);
            for (int dr = 0; dr < 4; dr++) begin
                data_in = {NCH{dr[0]}};
                rcv_in  = {NCH{dr[1]}};
                tick(1);
                check_chans("R6");
            end
        end

        // R7: comparator pass-through
        for (int v = 0; v < 16; v++) begin
            cmp_hi_in = 4'(v);
            cmp_lo_in = 4'(~v);
            tick(1);
            chk("R7 hi", {28'd0, cmp_hi_out}, v);
            chk("R7 lo", {28'd0, cmp_lo_out}, {28'd0, 4'(~v)});
        end

        // R4: load line holds then transfers
        data_in = 4'b0101;
        rcv_in  = 4'b0011;
        ld = 1'b1;
        tick(6);
        send_bits({4'd0, 4'hF, 2'b00, 6'h3C}, 12);
        check_chans("R4 hold");
        ld = 1'b0;
        tick(6);
        apply_model();
        check_chans("R4 transfer");
        ld = 1'b1;
        tick(6);
        send_bits({4'd0, 4'b1001, 2'b00, 6'h17}, 12);
        check_chans("R4 hold2");
        ld = 1'b0;
        tick(6);
        apply_model();
        check_chans("R4 transfer2");

        // R9: serial output repeats the previous word during the next
        wa = 12'hA5C;
        wb = 12'h3C1;
        send_bits({4'd0, wa}, 12);
        send_bits({4'd0, wb}, 12);
        for (int k = 0; k < 12; k++)
            chk("R9 dout", {31'd0, dout_seen[k]}, {31'd0, wa[k]});
        check_chans("R9 word");

        // R8: frame length errors
        chk("R8 no error", {31'd0, frame_err}, 32'd0);
        send_bits(16'h005A, 8);
        chk("R8 short sets", {31'd0, frame_err}, {31'd0, m_ferr});
        check_chans("R8 short captures");
        send_bits({4'd0, 12'hF21}, 12);
        chk("R8 sticky", {31'd0, frame_err}, 32'd1);
        err_clr = 1'b1;
        tick(1);
        err_clr = 1'b0;
        tick(2);
        m_ferr = 1'b0;
        chk("R8 clear", {31'd0, frame_err}, 32'd0);
        send_bits(16'h1F0E, 13);
        chk("R8 long sets", {31'd0, frame_err}, 32'd1);
        check_chans("R8 long captures");
        err_clr = 1'b1;
        tick(1);
        err_clr = 1'b0;
        tick(2);
        chk("R8 clear2", {31'd0, frame_err}, 32'd0);
        send_bits(16'h0000, 0);
        chk("R8 empty sets", {31'd0, frame_err}, 32'd1);
        check_chans("R8 empty captures");

        finish_up();
    end
endmodule